// File: doc/BRIEF.md
# Programming-Enable Synchronization Sequencer

This block brings a target device into serial programming mode. A start request makes it pulse the target's reset line high for a programmable hold time, release it, and wait a programmable settle time. It then issues the four-byte programming-enable instruction through a byte-wide request/acknowledge handshake to an external SPI master. The master shifts each byte most significant bit first and parks SCK low while no byte is in flight.

The target proves that it is in step with the clock by returning the instruction's second byte in the third byte slot. When that echo is missing, the sequencer completes the instruction with a filler fourth byte. It then asks the master, over a separate single-pulse handshake, for one lone SCK pulse, which shifts the bit alignment by one position, and starts the instruction again. After a bounded number of attempts it gives up. When it finishes, either way, it reports whether synchronization was reached and how many echo checks were used.

All delay lengths arrive as input values and are counted in clock cycles. The block does no bit shifting of its own.

Top module: `pe_sync_seq`

## Requirements
- R1: After reset, tgt_rst_o, spi_req_o, sck_pulse_req_o, busy_o, done_o and sync_ok_o are 0 and tries_o is 0.
- R2: When start_i is sampled high while idle, tgt_rst_o is high from the next cycle for exactly rst_hold_i+1 cycles, and no byte or pulse request is made while it is high.
- R3: After tgt_rst_o falls, exactly settle_i+1 cycles pass before spi_req_o first rises.
- R4: Each attempt requests the bytes 0xAC, 0x53, 0x00, 0x00 in that order. Each byte stays on spi_tx_o with spi_req_o high until a cycle with spi_ack_i high. When a further byte follows, the next byte is presented in the cycle after the acknowledge.
- R5: When spi_rx_i equals 0x53 on the acknowledge of the third byte, sync_ok_o rises in the next cycle. The fourth byte (0x00) is then sent, and post_i+1 cycles after its acknowledge the sequence ends.
- R6: When the third-byte echo differs from 0x53 and attempts remain, the 0x00 fourth byte is followed by sck_pulse_req_o, held until sck_pulse_ack_i. The next cycle restarts the attempt with 0xAC.
- R7: At most MAX_TRIES (default 32) echo checks are made. After a mismatch on the last one, the fourth byte is sent, the post delay runs, and the sequence ends with sync_ok_o low and tries_o equal to MAX_TRIES.
- R8: tries_o counts the echo checks of the current sequence. It is cleared when a start is accepted and holds its final value while idle.
- R9: done_o is a single-cycle pulse in the first cycle that busy_o is low after a sequence.
- R10: start_i has no effect while busy_o is high.
- R11: spi_req_o and sck_pulse_req_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a programming-enable sequence |
| rst_hold_i | input | DLY_W | Reset-high hold length, cycles minus one |
| settle_i | input | DLY_W | Settle length after reset release, cycles minus one |
| post_i | input | DLY_W | Settle length after the final byte, cycles minus one |
| tgt_rst_o | output | 1 | Target reset line |
| spi_req_o | output | 1 | Byte transfer request to the SPI master |
| spi_tx_o | output | 8 | Byte to shift out |
| spi_ack_i | input | 1 | Byte transfer finished; spi_rx_i valid |
| spi_rx_i | input | 8 | Byte shifted in |
| sck_pulse_req_o | output | 1 | Request for one lone SCK pulse |
| sck_pulse_ack_i | input | 1 | Lone pulse issued |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| sync_ok_o | output | 1 | Echo matched in this sequence |
| tries_o | output | ATT_W | Echo checks used |

## Verification
Every cycle, the assertions check the handshake rules: requests held until their acknowledge, stable bytes while waiting, the two requests exclusive, no traffic while reset is high, and a fresh attempt always opening with 0xAC. They also check the bound on tries_o, the single-cycle done pulse, and that results stay frozen while idle. The exact reset and settle lengths, the byte order and the echo decision depend on acknowledge latency and on the echoed data. Only the bench's scenarios can show those: immediate success, several misaligned echoes before a match, every attempt failing, and a start pulsed mid-sequence. Each is compared cycle by cycle against a behavioural model.

// File: rtl/pe_sync_pkg.sv
package pe_sync_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RST_HI, ST_SETTLE, ST_XFER, ST_SLIP, ST_POST
  } st_e;

  typedef enum logic [1:0] {SL_B1, SL_B2, SL_B3, SL_B4} slot_e;

  localparam logic [7:0] PE_OP   = 8'hAC;
  localparam logic [7:0] PE_SYNC = 8'h53;
  localparam logic [7:0] PE_FILL = 8'h00;
endpackage

// File: rtl/pe_dly_tmr.sv
module pe_dly_tmr #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pe_tx_sel.sv
module pe_tx_sel
  import pe_sync_pkg::*;
(
  input  slot_e       slot_i,
  output logic [7:0]  byte_o
);
  always_comb begin
    unique case (slot_i)
      SL_B1:   byte_o = PE_OP;
      SL_B2:   byte_o = PE_SYNC;
      default: byte_o = PE_FILL;
    endcase
  end
endmodule

// File: rtl/pe_try_ctr.sv
module pe_try_ctr #(
  parameter int unsigned MAX_TRIES = 32,
  parameter int unsigned W         = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  localparam logic [W-1:0] LIMIT = W'(MAX_TRIES);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (inc_i && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == LIMIT);
endmodule

// File: rtl/pe_sync_seq.sv
module pe_sync_seq
  import pe_sync_pkg::*;
#(
  parameter int unsigned DLY_W     = 16,
  parameter int unsigned MAX_TRIES = 32,
  localparam int unsigned ATT_W    = $clog2(MAX_TRIES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DLY_W-1:0] rst_hold_i,
  input  logic [DLY_W-1:0] settle_i,
  input  logic [DLY_W-1:0] post_i,
  output logic             tgt_rst_o,
  output logic             spi_req_o,
  output logic [7:0]       spi_tx_o,
  input  logic             spi_ack_i,
  input  logic [7:0]       spi_rx_i,
  output logic             sck_pulse_req_o,
  input  logic             sck_pulse_ack_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             sync_ok_o,
  output logic [ATT_W-1:0] tries_o
);
  st_e              st_q, st_d;
  slot_e            slot_q, slot_d;
  logic             ok_q, ok_d;
  logic             done_q, done_d;
  logic             tmr_load, tmr_zero;
  logic [DLY_W-1:0] tmr_val;
  logic             try_clr, try_inc, try_last;

  pe_dly_tmr #(.W(DLY_W)) i_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  pe_try_ctr #(.MAX_TRIES(MAX_TRIES), .W(ATT_W)) i_try (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (try_clr),
    .inc_i  (try_inc),
    .cnt_o  (tries_o),
    .last_o (try_last)
  );

  pe_tx_sel i_tx (
    .slot_i (slot_q),
    .byte_o (spi_tx_o)
  );

  always_comb begin
    st_d     = st_q;
    slot_d   = slot_q;
    ok_d     = ok_q;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    try_clr  = 1'b0;
    try_inc  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d     = ST_RST_HI;
        tmr_load = 1'b1;
        tmr_val  = rst_hold_i;
        try_clr  = 1'b1;
        ok_d     = 1'b0;
        slot_d   = SL_B1;
      end
      ST_RST_HI: if (tmr_zero) begin
        st_d     = ST_SETTLE;
        tmr_load = 1'b1;
        tmr_val  = settle_i;
      end
      ST_SETTLE: if (tmr_zero) begin
        st_d   = ST_XFER;
        slot_d = SL_B1;
      end
      ST_XFER: if (spi_ack_i) begin
        unique case (slot_q)
          SL_B1: slot_d = SL_B2;
          SL_B2: slot_d = SL_B3;
          SL_B3: begin
            slot_d  = SL_B4;
            try_inc = 1'b1;
            if (spi_rx_i == PE_SYNC) ok_d = 1'b1;
          end
          SL_B4: begin
            // echo seen or attempts used up: finish, else slip one bit
            if (ok_q || try_last) begin
              st_d     = ST_POST;
              tmr_load = 1'b1;
              tmr_val  = post_i;
            end else begin
              st_d = ST_SLIP;
            end
          end
        endcase
      end
      ST_SLIP: if (sck_pulse_ack_i) begin
        st_d   = ST_XFER;
        slot_d = SL_B1;
      end
      ST_POST: if (tmr_zero) begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      slot_q <= SL_B1;
      ok_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      slot_q <= slot_d;
      ok_q   <= ok_d;
      done_q <= done_d;
    end
  end

  assign tgt_rst_o       = (st_q == ST_RST_HI);
  assign spi_req_o       = (st_q == ST_XFER);
  assign sck_pulse_req_o = (st_q == ST_SLIP);
  assign busy_o          = (st_q != ST_IDLE);
  assign done_o          = done_q;
  assign sync_ok_o       = ok_q;
endmodule

// File: rtl/pe_sync_seq_chk.sv
module pe_sync_seq_chk #(
  parameter int unsigned MAX_TRIES = 32,
  parameter int unsigned ATT_W     = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             tgt_rst_o,
  input logic             spi_req_o,
  input logic [7:0]       spi_tx_o,
  input logic             spi_ack_i,
  input logic             sck_pulse_req_o,
  input logic             sck_pulse_ack_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             sync_ok_o,
  input logic [ATT_W-1:0] tries_o
);
  p_req_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(spi_req_o && sck_pulse_req_o));

  p_no_spi_in_rst_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_rst_o |-> !spi_req_o && !sck_pulse_req_o);

  p_byte_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_req_o && !spi_ack_i |=> spi_req_o && $stable(spi_tx_o));

  p_first_byte_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spi_req_o) |-> spi_tx_o == 8'hAC);

  p_pulse_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_pulse_req_o && !sck_pulse_ack_i |=> sck_pulse_req_o);

  p_slip_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_pulse_req_o && sck_pulse_ack_i |=> spi_req_o && spi_tx_o == 8'hAC);

  p_tries_cap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tries_o <= ATT_W'(MAX_TRIES));

  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(tries_o) && $stable(sync_ok_o));
endmodule

bind pe_sync_seq pe_sync_seq_chk #(.MAX_TRIES(MAX_TRIES), .ATT_W(ATT_W)) i_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .start_i         (start_i),
  .tgt_rst_o       (tgt_rst_o),
  .spi_req_o       (spi_req_o),
  .spi_tx_o        (spi_tx_o),
  .spi_ack_i       (spi_ack_i),
  .sck_pulse_req_o (sck_pulse_req_o),
  .sck_pulse_ack_i (sck_pulse_ack_i),
  .busy_o          (busy_o),
  .done_o          (done_o),
  .sync_ok_o       (sync_ok_o),
  .tries_o         (tries_o)
);

// File: tb/test_pe_sync_seq.sv
`timescale 1ns/1ps
module test_pe_sync_seq;
  localparam int MAXT = 32;
  localparam int AW   = $clog2(MAXT + 1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] hold_v = '0, settle_v = '0, post_v = '0;
  logic spi_ack = 1'b0, pls_ack = 1'b0;
  logic [7:0] spi_rx = '0;
  logic tgt_rst, spi_req, pls_req, busy, done, sync_ok;
  logic [7:0] spi_tx;
  logic [AW-1:0] tries;

  pe_sync_seq #(.DLY_W(16), .MAX_TRIES(MAXT)) i_pe_sync_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .rst_hold_i(hold_v), .settle_i(settle_v), .post_i(post_v),
    .tgt_rst_o(tgt_rst), .spi_req_o(spi_req), .spi_tx_o(spi_tx),
    .spi_ack_i(spi_ack), .spi_rx_i(spi_rx),
    .sck_pulse_req_o(pls_req), .sck_pulse_ack_i(pls_ack),
    .busy_o(busy), .done_o(done), .sync_ok_o(sync_ok), .tries_o(tries)
  );

  always #2.5 clk = ~clk;

  int n_vec = 0, n_bad = 0, cyc = 0, lat = 0;
  logic [7:0] rx_q[$];

  task automatic check(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // SPI master stand-in: acks after lat idle cycles, returns queued bytes
  int sw = 0, pw = 0;
  always @(negedge clk) begin
    logic was_s, was_p;
    cyc++;
    was_s = spi_ack; was_p = pls_ack;
    spi_ack = 1'b0; pls_ack = 1'b0;
    if (rst_n && spi_req && !was_s) begin
      if (sw >= lat) begin
        spi_ack = 1'b1; sw = 0;
        spi_rx = (rx_q.size() != 0) ? rx_q.pop_front() : 8'hFF;
      end else sw++;
    end
    if (rst_n && pls_req && !was_p) begin
      if (pw >= lat) begin pls_ack = 1'b1; pw = 0; end
      else pw++;
    end
  end

  // behavioural reference
  logic e_rst = 0, e_req = 0, e_preq = 0, e_busy = 0, e_done = 0, e_ok = 0;
  logic [7:0] e_tx = 0, last_rx = 0;
  int e_tries = 0;

  task automatic ref_xfer(logic [7:0] b);
    e_req = 1'b1; e_tx = b;
    do @(posedge clk); while (!spi_ack);
    last_rx = spi_rx;
  endtask

  initial begin
    int h, s, p;
    @(posedge rst_n);
    forever begin
      @(posedge clk);
      e_done = 1'b0;
      if (start) begin
        h = hold_v; s = settle_v; p = post_v;
        e_busy = 1; e_rst = 1; e_ok = 0; e_tries = 0;
        repeat (h + 1) @(posedge clk);
        e_rst = 0;
        repeat (s + 1) @(posedge clk);
        forever begin
          ref_xfer(8'hAC);
          ref_xfer(8'h53);
          ref_xfer(8'h00);
          e_tries++;
          if (last_rx == 8'h53) e_ok = 1;
          ref_xfer(8'h00);
          if (e_ok || e_tries == MAXT) break;
          e_req = 0; e_preq = 1;
          do @(posedge clk); while (!pls_ack);
          e_preq = 0;
        end
        e_req = 0;
        repeat (p + 1) @(posedge clk);
        e_busy = 0; e_done = 1;
      end
    end
  end

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      check("R2 tgt_rst", tgt_rst, e_rst);
      check("R4 spi_req", spi_req, e_req);
      if (e_req) check("R4 spi_tx", spi_tx, e_tx);
      check("R6 pulse_req", pls_req, e_preq);
      check("R10 busy", busy, e_busy);
      check("R9 done", done, e_done);
      check("R5 sync_ok", sync_ok, e_ok);
      check("R8 tries", tries, e_tries);
      if (spi_req && pls_req) check("R11 exclusive", 1, 0);
    end
  end

  // reset/settle length monitor
  int rise_c = 0, fall_c = 0, req_c = 0;
  logic prv_rst = 0, armed = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (tgt_rst && !prv_rst) rise_c = cyc;
      if (!tgt_rst && prv_rst) begin fall_c = cyc; armed = 1; end
      if (armed && spi_req) begin req_c = cyc; armed = 0; end
      prv_rst = tgt_rst;
    end
  end

  task automatic run(int h, int s, int p, int l, int nfail, bit ok, bit mid_start);
    hold_v = 16'(h); settle_v = 16'(s); post_v = 16'(p); lat = l;
    rx_q.delete();
    for (int i = 0; i < nfail; i++) begin
      rx_q.push_back(8'hA5); rx_q.push_back(8'hA5);
      rx_q.push_back((i % 2) ? 8'h29 : 8'hA6); rx_q.push_back(8'hA5);
    end
    if (ok) begin
      rx_q.push_back(8'hA5); rx_q.push_back(8'hA5);
      rx_q.push_back(8'h53); rx_q.push_back(8'hA5);
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (mid_start) begin
      repeat (h + s + 4) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    do @(negedge clk); while (!done);
    check("R2 reset width", fall_c - rise_c, h + 1);
    check("R3 settle width", req_c - fall_c, s + 1);
    check("R5 sync_ok at end", sync_ok, ok);
    check("R7 tries at end", tries, ok ? nfail + 1 : nfail);
    @(negedge clk);
    check("R9 done width", done, 0);
    check("R8 tries held", tries, ok ? nfail + 1 : nfail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 tgt_rst", tgt_rst, 0);
    check("R1 spi_req", spi_req, 0);
    check("R1 pulse_req", pls_req, 0);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 sync_ok", sync_ok, 0);
    check("R1 tries", tries, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run(3, 2, 4, 0, 0, 1, 0);       // R5 immediate match
    run(1, 5, 2, 2, 3, 1, 0);       // R6 slips before match
    run(0, 0, 0, 1, MAXT, 0, 0);    // R7 all attempts fail
    run(4, 1, 3, 0, 2, 1, 1);       // R10 start while busy
    run(0, 0, 0, 0, MAXT - 1, 1, 0);// R7 match on last attempt
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    n_vec++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule